// File: doc/BRIEF.md
# BCD Stopwatch Timer

This block keeps the sub-second part of a software stopwatch. It runs from a one-cycle strobe that arrives at 256 Hz (a 32.768 kHz crystal divided by 128). A feedback divider turns that strobe into steps of a hundredths digit. Each step takes two or three strobes, so the steps come at about 100 Hz. When the hundredths digit wraps, the tenths digit advances, and when the tenths digit wraps a one-second event fires. The step lengths are chosen so that exactly 256 strobes make one second. Software keeps the seconds and minutes by counting the one-second events.

Software uses a small register port to start and stop the count, clear the digits and divider phase, read both digits, and handle three interrupt sources. The sources are the hundredths step, the tenths step and the one-second wrap. Each source has a sticky flag and an enable, and the block has one combined request line.

Top module: `bcd_stopwatch`

## Requirements
- R1: After reset, every register reads 0 and irq_o is low. The digits, the divider phase, the run bit, the enables and the flags are all cleared.
- R2: Address 1 reads the count, with hundredths in bits [3:0] and tenths in bits [7:4]. Both are BCD digits that never exceed 9.
- R3: The tenths digit advances only on the step in which hundredths goes from 9 to 0. The tenths digit itself wraps from 9 to 0.
- R4: A running step completes after 3 strobes when hundredths is even and after 2 strobes when it is odd. The exception is hundredths 9 while tenths is 0, 2, 4, 5, 7 or 9: that step takes 3 strobes. From a cleared state, 25 strobes give count 0x09, 26 give 0x10, 51 give 0x20 and 256 give 0x00.
- R5: Address 0 bit 0 is the run bit. While it is 0, strobes are ignored: the digits and the divider phase hold, and counting resumes from the same phase.
- R6: Writing 1 to address 0 bit 1 clears both digits and the divider phase on that clock edge, even if a strobe arrives in the same cycle. The bit always reads back as 0, and the same write also loads the run bit.
- R7: Address 3 holds the flags: bit 0 for a hundredths step, bit 1 for a tenths step and bit 2 for a tenths wrap. A flag stays set until software writes 1 to it. If a new event arrives in the same cycle as the clearing write, the flag stays set.
- R8: Address 2 bits [2:0] enable the flags bit for bit. irq_o is high exactly when some flag is set together with its enable.
- R9: A clear through address 0 bit 1 leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 256 Hz strobe, one clock wide |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A strobe or a register write presented in one cycle takes effect at the next rising edge. The new digits, flags and enables, and with them irq_o, are therefore visible from that edge on. Reads are combinational, so rdata_o follows addr_i within the same cycle. The bench reference model updates at each rising edge from the inputs the bench held across that edge. The bench compares rdata_o and irq_o at the following falling edge, and drives new inputs one step after that edge, so every comparison sees the state exactly one edge after its stimulus. The named checks read a register one cycle after setting the address, with no strobe pending.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int DIG_W   = 4;
  localparam int N_DIG   = 2;
  localparam int N_SRC   = N_DIG + 1;
  localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

  typedef logic [DIG_W-1:0] digit_t;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_IEN   = 2'd2,
    A_IFLG  = 2'd3
  } addr_e;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_CLR = 1;

  // six of ten tenth-periods get one extra strobe, spread over the second
  function automatic logic long_tenth(digit_t t);
    logic [7:0] p;
    p = 8'(t) * 8'd6;
    return (p % 8'd10) < 8'd6;
  endfunction
endpackage

// File: rtl/bsw_divider.sv
module bsw_divider
  import bsw_pkg::*;
#(
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   run_i,
  input  logic   tick_i,
  input  digit_t lsd_i,
  input  digit_t msd_i,
  output logic   step_o
);
  localparam int CNT_W = $clog2(LONG_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             long_step;
  logic             last;

  always_comb begin
    long_step = !lsd_i[0] || (lsd_i == DIG_MAX && long_tenth(msd_i));
    last      = (cnt_q == (long_step ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1)));
  end

  assign step_o = tick_i && run_i && !clr_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (tick_i && run_i)  cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/bsw_digit.sv
module bsw_digit
  import bsw_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   inc_i,
  output digit_t val_o,
  output logic   carry_o
);
  digit_t val_q;

  assign carry_o = inc_i && (val_q == DIG_MAX);
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (clr_i)  val_q <= '0;
    else if (inc_i)  val_q <= carry_o ? '0 : val_q + DIG_W'(1);
  end
endmodule

// File: rtl/bsw_irq.sv
module bsw_irq
  import bsw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] ev_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] flags_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] flg_q;

  // set wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~ack_i) | ev_i;
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & en_i);
endmodule

// File: rtl/bsw_regs.sv
module bsw_regs
  import bsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  digit_t [N_DIG-1:0]      digits_i,
  input  logic [N_SRC-1:0]        flags_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    run_o,
  output logic                    clr_o,
  output logic [N_SRC-1:0]        en_o,
  output logic [N_SRC-1:0]        ack_o
);
  logic             wr;
  logic             run_q;
  logic [N_SRC-1:0] en_q;

  assign wr    = req_i && we_i;
  assign clr_o = wr && (addr_i == ADDR_W'(A_CTRL)) && wdata_i[CTRL_CLR];
  assign ack_o = (wr && (addr_i == ADDR_W'(A_IFLG))) ? wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      en_q  <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(A_CTRL)) run_q <= wdata_i[CTRL_RUN];
      if (addr_i == ADDR_W'(A_IEN))  en_q  <= wdata_i[N_SRC-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CTRL):  rdata_o[CTRL_RUN] = run_q;
      ADDR_W'(A_COUNT): rdata_o = DATA_W'(digits_i);
      ADDR_W'(A_IEN):   rdata_o = DATA_W'(en_q);
      default:          rdata_o = DATA_W'(flags_i);
    endcase
  end

  assign run_o = run_q;
  assign en_o  = en_q;
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch
  import bsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  digit_t [N_DIG-1:0] digits;
  logic   [N_DIG:0]   carry;
  logic   [N_SRC-1:0] flags;
  logic   [N_SRC-1:0] en;
  logic   [N_SRC-1:0] ack;
  logic               run;
  logic               clr;

  bsw_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .digits_i(digits), .flags_i(flags), .rdata_o,
    .run_o(run), .clr_o(clr), .en_o(en), .ack_o(ack)
  );

  bsw_divider u_div (
    .clk_i, .rst_ni, .clr_i(clr), .run_i(run), .tick_i,
    .lsd_i(digits[0]), .msd_i(digits[1]), .step_o(carry[0])
  );

  for (genvar i = 0; i < N_DIG; i++) begin : g_dig
    bsw_digit u_dig (
      .clk_i, .rst_ni, .clr_i(clr), .inc_i(carry[i]),
      .val_o(digits[i]), .carry_o(carry[i+1])
    );
  end

  bsw_irq u_irq (
    .clk_i, .rst_ni, .ev_i(carry), .ack_i(ack), .en_i(en),
    .flags_o(flags), .irq_o
  );
endmodule

// File: rtl/bcd_stopwatch_chk.sv
module bcd_stopwatch_chk
  import bsw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [7:0]       wdata_i,
  input logic             irq_o,
  input digit_t           hund_i,
  input digit_t           tenth_i,
  input logic             run_i,
  input logic [N_SRC-1:0] flags_i,
  input logic [N_SRC-1:0] en_i
);
  logic clr_w, ack_w;
  assign clr_w = req_i && we_i && addr_i == 2'd0 && wdata_i[1];
  assign ack_w = req_i && we_i && addr_i == 2'd3 && (|wdata_i[N_SRC-1:0]);

  p_digit_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hund_i <= DIG_MAX && tenth_i <= DIG_MAX);

  p_tenth_on_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(tenth_i) && !$past(clr_w)) |-> ($past(hund_i) == DIG_MAX && hund_i == '0));

  p_step_needs_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(hund_i) && !$past(clr_w)) |-> ($past(tick_i) && $past(run_i)));

  p_hold_stopped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_w) |=> ($stable(hund_i) && $stable(tenth_i)));

  p_clear_zeroes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> (hund_i == '0 && tenth_i == '0));

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flags_i) & ~flags_i) != '0) |-> $past(ack_w));

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_o);

  p_clear_keeps_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && !ack_w) |=> ((flags_i & $past(flags_i)) == $past(flags_i)));
endmodule

bind bcd_stopwatch bcd_stopwatch_chk u_chk (
  .clk_i, .rst_ni, .tick_i, .req_i, .we_i, .addr_i, .wdata_i, .irq_o,
  .hund_i(digits[0]), .tenth_i(digits[1]), .run_i(run),
  .flags_i(flags), .en_i(en)
);

// File: tb/sim_bcd_stopwatch.sv
module sim_bcd_stopwatch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  int m_h = 0, m_t = 0, m_ph = 0, m_run = 0, m_en = 0, m_flg = 0;

  always #5 clk = ~clk;

  bcd_stopwatch u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic bit long_t(int t);
    case (t)
      0, 2, 4, 5, 7, 9: return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_t = 0; m_ph = 0; m_run = 0; m_en = 0; m_flg = 0;
    end else begin
      int ev, len;
      bit wr, clr;
      ev  = 0;
      wr  = req && we;
      clr = wr && addr == 2'd0 && wdata[1];
      len = (m_h % 2 == 0 || (m_h == 9 && long_t(m_t))) ? 3 : 2;
      if (clr) begin
        m_h = 0; m_t = 0; m_ph = 0;
      end else if (tick && m_run != 0) begin
        m_ph++;
        if (m_ph == len) begin
          m_ph = 0; ev = 1;
          if (m_h == 9) begin
            m_h = 0; ev |= 2;
            if (m_t == 9) begin m_t = 0; ev |= 4; end
            else m_t++;
          end else m_h++;
        end
      end
      if (wr && addr == 2'd0) m_run = int'(wdata[0]);
      if (wr && addr == 2'd2) m_en  = int'(wdata[2:0]);
      if (wr && addr == 2'd3) m_flg = m_flg & ~int'(wdata[2:0]);
      m_flg |= ev;
    end
  end

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return {7'd0, m_run[0]};
      2'd1:    return {m_t[3:0], m_h[3:0]};
      2'd2:    return {5'd0, m_en[2:0]};
      default: return {5'd0, m_flg[2:0]};
    endcase
  endfunction

  task automatic chk(string r, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", r, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, int'(rdata), int'(exp_rd(addr)));
      chk(cur_req, int'(irq), int'((m_flg & m_en) != 0));
    end
  end

  task automatic drive(bit t, bit rq, bit w, logic [1:0] a, logic [7:0] d);
    @(negedge clk); #1;
    tick = t; req = rq; we = w; addr = a; wdata = d;
  endtask

  task automatic idle(); drive(0, 0, 0, 2'd1, 8'd0); endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    drive(0, 1, 1, a, d); idle();
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      drive(1, 0, 0, 2'd1, 8'd0);
      for (int g = 0; g < gap; g++) idle();
    end
  endtask

  task automatic expect_reg(logic [1:0] a, int exp, string r);
    drive(0, 0, 0, a, 8'd0);
    @(negedge clk);
    chk(r, int'(rdata), exp);
  endtask

  task automatic expect_irq(int exp, string r);
    idle();
    @(negedge clk);
    chk(r, int'(irq), exp);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    expect_reg(2'd0, 0, "R1"); expect_reg(2'd1, 0, "R1");
    expect_reg(2'd2, 0, "R1"); expect_reg(2'd3, 0, "R1");
    expect_irq(0, "R1");

    // R4 uneven step pattern, R3 tenths carry
    cur_req = "R4";
    wr_reg(2'd0, 8'h03);
    ticks(25, 1); expect_reg(2'd1, 8'h09, "R4");
    ticks(1, 1);  expect_reg(2'd1, 8'h10, "R3");
    ticks(25, 1); expect_reg(2'd1, 8'h20, "R4");
    ticks(205, 1); expect_reg(2'd1, 8'h00, "R4");
    expect_reg(2'd3, 8'h07, "R7");

    // R5 stop holds digits and phase
    cur_req = "R5";
    ticks(7, 1); expect_reg(2'd1, 8'h02, "R5");
    wr_reg(2'd0, 8'h00);
    ticks(20, 0); expect_reg(2'd1, 8'h02, "R5");
    wr_reg(2'd0, 8'h01);
    ticks(1, 1); expect_reg(2'd1, 8'h03, "R5");

    // R6 clear with coincident strobe; R9 flags untouched
    cur_req = "R6";
    drive(1, 1, 1, 2'd0, 8'h03); idle();
    expect_reg(2'd1, 8'h00, "R6");
    expect_reg(2'd0, 8'h01, "R6");
    cur_req = "R9";
    expect_reg(2'd3, 8'h07, "R9");

    // R7 write-one-to-clear
    cur_req = "R7";
    wr_reg(2'd3, 8'h01); expect_reg(2'd3, 8'h06, "R7");
    wr_reg(2'd3, 8'h06); expect_reg(2'd3, 8'h00, "R7");

    // R8 enables and request
    cur_req = "R8";
    wr_reg(2'd2, 8'h01); expect_irq(0, "R8");
    ticks(3, 1); expect_irq(1, "R8");
    wr_reg(2'd2, 8'h00); expect_irq(0, "R8");
    wr_reg(2'd2, 8'h04); expect_irq(0, "R8");

    // R7 set beats same-cycle clear (hundredths 1, phase 0, step of 2)
    cur_req = "R7";
    ticks(1, 1);
    drive(1, 1, 1, 2'd3, 8'h01); idle();
    expect_reg(2'd3, 8'h01, "R7");
    expect_reg(2'd1, 8'h02, "R7");

    // R2 long run with irregular strobe spacing
    cur_req = "R2";
    wr_reg(2'd2, 8'h07);
    lfsr = 8'hA5;
    for (int i = 0; i < 1200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ticks(1, int'(lfsr[1:0]));
      if (i % 100 == 50) wr_reg(2'd3, 8'h07);
    end
    expect_reg(2'd1, int'({m_t[3:0], m_h[3:0]}), "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule